// File: doc/BRIEF.md
# USB Host Receive-Endpoint Transaction Engine

This block drives the IN transactions of a single receive endpoint on the host side of a USB link. Software, or the engine itself through auto-request, sets a request flag. The engine then asks the link layer to send an IN token. It classifies what comes back as data, NAK, STALL or a bad/missing response, and applies a separate policy to each. Data raises a receive-ready flag and an interrupt. A NAK is retried, up to an optional limit. A STALL ends the request. A bad response is retried until the third failure, which ends the request with an error flag.

Once a packet has landed, software unloads it from the receive FIFO. Receive-ready is then cleared either by software or automatically when a full maximum-payload of bytes has been read. Every such clear sends a one-cycle acknowledge request to the link layer. With auto-request on, the clear also re-arms the next request. A down-counting packet budget can switch auto-request off after a set number of requests. With the budget at zero, a short packet switches it off instead.

Top module: `usb_in_sched`

## Requirements
- R1: After the request flag (status register 0, bit 0) is set while receive-ready is clear, `tok_req` rises, and it stays high until a cycle with `tok_ack` high.
- R2: A response of kind 0 (data) sets receive-ready (register 0 bit 1), clears the request flag and raises `irq`. No token is requested while receive-ready is set.
- R3: A software write to register 0 with bit 1 at 0 while receive-ready is set clears it and pulses `ack_send` for one cycle. Writing 1 to bit 1 has no effect.
- R4: With auto-request (register 1 bit 1) set, every clear of receive-ready sets the request flag again, and a new token follows.
- R5: With auto-clear (register 1 bit 0) set, receive-ready clears itself, with an `ack_send` pulse, on the `fifo_rd` strobe that brings the count of bytes read since the packet landed up to the maximum payload (register 2).
- R6: A nonzero packet budget (register 3) drops by one on the first token of each request, not on retries. When it drops from 1 to 0, auto-request is cleared.
- R7: With the budget at zero, a data response whose byte count is below the maximum payload clears auto-request.
- R8: A response of kind 1 (NAK) is retried. With a nonzero NAK limit (register 4), the limit-th consecutive NAK clears the request flag and sets the NAK-timeout flag (register 0 bit 4). A limit of zero retries forever.
- R9: A response of kind 2 (STALL) clears the request flag, sets the stalled flag (register 0 bit 2) and is not retried.
- R10: A response of kind 3 (timeout or corrupt) is retried. The third in a row clears the request flag and sets the error flag (register 0 bit 3). Any data or NAK response, and any new request, resets the run count.
- R11: Status flags in register 0 bits 2 to 4 stay set until software writes 0 to them; writing 1 leaves them as they are. `irq` is the OR of receive-ready and these three flags.
- R12: A software write of 0 to the request bit while a response is awaited stops any retry of that request: no further token is requested.
- R13: After reset, all registers read zero, `tok_req`, `ack_send` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 status, 1 mode, 2 max payload, 3 packet budget, 4 NAK limit) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| tok_req | output | 1 | Request to the link layer to send an IN token |
| tok_ack | input | 1 | Link layer has accepted the token |
| rsp_valid | input | 1 | One-cycle report of the device response |
| rsp_kind | input | 2 | Response kind: 0 data, 1 NAK, 2 STALL, 3 timeout/corrupt |
| rsp_bytes | input | 11 | Byte count of a data response |
| fifo_rd | input | 1 | One byte unloaded from the receive FIFO |
| ack_send | output | 1 | One-cycle request to acknowledge the received packet |
| irq | output | 1 | Endpoint interrupt |

## Verification
The assertions assume a well-behaved link layer. It raises `tok_ack` only while `tok_req` is high and returns exactly one `rsp_valid` pulse per accepted token. It never reports a response while no token is outstanding. They also assume software writes and `fifo_rd` strobes do not land in the same cycle as a response. The bench respects this by serving each token from a single sequential device-model task, which acknowledges the token and then reports one response a cycle later. Register writes and FIFO reads are issued only between such exchanges, apart from the deliberate abort, which falls in the waiting cycle before the response.

// File: rtl/uis_pkg.sv
// Shared types for the receive-endpoint transaction engine.
// Assumes: response kinds are encoded on two bits by the link layer.
package uis_pkg;
    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_BAD   = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TOKEN = 2'd1,
        ST_WAIT  = 2'd2
    } eng_state_e;

    // Bit positions in the status register (software decodes these).
    localparam int B_REQ   = 0;
    localparam int B_RXRDY = 1;
    localparam int B_STALL = 2;
    localparam int B_ERROR = 3;
    localparam int B_NAKTO = 4;
    // Bit positions in the mode register.
    localparam int B_ACLR  = 0;
    localparam int B_AREQ  = 1;
endpackage

// File: rtl/uis_retry.sv
// Retry policy: counts consecutive NAKs and consecutive bad responses.
// Flags when the NAK limit or the bad-response limit ends a request.
// Assumes: judge pulses only when a response arrives for an issued token.
module uis_retry #(
    parameter int NAKL_W    = 8,
    parameter int ERR_TRIES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  judge,
    input  uis_pkg::rsp_kind_e    kind,
    input  logic [NAKL_W-1:0]     nak_lim,
    output logic                  nak_expire,
    output logic                  err_expire
);
    import uis_pkg::*;
    localparam int EW = $clog2(ERR_TRIES + 1);

    logic [NAKL_W-1:0] nak_cnt;
    logic [EW-1:0]     err_cnt;

    // Limit decisions taken in the cycle the response is judged.
    assign nak_expire = judge && (kind == RSP_NAK) && (nak_lim != '0) &&
                        (({1'b0, nak_cnt} + (NAKL_W+1)'(1)) >= {1'b0, nak_lim});
    assign err_expire = judge && (kind == RSP_BAD) && (err_cnt == EW'(ERR_TRIES - 1));

    // Consecutive-response counters, cleared by a fresh request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            nak_cnt <= '0;
            err_cnt <= '0;
        end else if (judge) begin
            case (kind)
                RSP_DATA: begin
                    nak_cnt <= '0;
                    err_cnt <= '0;
                end
                RSP_NAK: begin
                    err_cnt <= '0;
                    if (nak_cnt != '1) nak_cnt <= nak_cnt + NAKL_W'(1);
                end
                RSP_BAD:  err_cnt <= err_expire ? '0 : err_cnt + EW'(1);
                default: ;
            endcase
        end
    end

    // R10
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt < EW'(ERR_TRIES));
endmodule

// File: rtl/uis_budget.sv
// Packet budget: a down-counter loaded by software.
// It steps once per request that is started, and flags the step to zero.
// Assumes: consume pulses only on the first accepted token of a request.
module uis_budget #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             consume,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_zero
);
    assign hit_zero = consume && (cnt == CNT_W'(1));

    // Load from software or step down on a started request.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (wr_en)                   cnt <= wr_val;
        else if (consume && cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !wr_en && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/uis_unload.sv
// Unload tracker: counts bytes read from the receive FIFO since the packet landed.
// Reports the strobe that completes a maximum-payload read.
// Assumes: rd_stb is meaningful only while armed (receive-ready set).
module uis_unload #(
    parameter int MAXP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              rd_stb,
    input  logic [MAXP_W-1:0] maxp,
    output logic              full_read
);
    logic [MAXP_W-1:0] rd_cnt;

    assign full_read = armed && rd_stb &&
                       (({1'b0, rd_cnt} + (MAXP_W+1)'(1)) >= {1'b0, maxp});

    // Byte counter, held at zero while no packet is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)               rd_cnt <= '0;
        else if (rd_stb && rd_cnt != '1)    rd_cnt <= rd_cnt + MAXP_W'(1);
    end
endmodule

// File: rtl/usb_in_sched.sv
// Host receive-endpoint transaction engine (top).
// It issues IN tokens, judges responses, keeps control/status registers,
// handles auto-clear and auto-request, and raises the endpoint interrupt.
// Assumes: one response per accepted token; tok_ack only while tok_req is high.
module usb_in_sched #(
    parameter int MAXP_W    = 11,
    parameter int CNT_W     = 8,
    parameter int NAKL_W    = 8,
    parameter int ERR_TRIES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              tok_req,
    input  logic              tok_ack,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [MAXP_W-1:0] rsp_bytes,
    input  logic              fifo_rd,
    output logic              ack_send,
    output logic              irq
);
    import uis_pkg::*;
    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_MAXP = 3'd2;
    localparam logic [2:0] A_BUDG = 3'd3;
    localparam logic [2:0] A_NAKL = 3'd4;

    eng_state_e        state;
    rsp_kind_e         kind;
    logic              req, rxrdy, stalled, err_flag, nak_to;
    logic              aclr_en, areq_en, fresh;
    logic [MAXP_W-1:0] maxp;
    logic [NAKL_W-1:0] nak_lim;
    logic [CNT_W-1:0]  budget;

    logic sw_stat, abort, sw_req_set, rx_clr, restart;
    logic tok_fire, judge, full_read, nak_expire, err_expire, hit_zero, is_short;

    assign kind       = rsp_kind_e'(rsp_kind);
    assign sw_stat    = reg_wr && (reg_addr == A_STAT);
    assign abort      = sw_stat && !reg_wdata[B_REQ];
    assign sw_req_set = sw_stat && reg_wdata[B_REQ] && !req;
    assign rx_clr     = rxrdy && ((sw_stat && !reg_wdata[B_RXRDY]) || (aclr_en && full_read));
    assign restart    = sw_req_set || (rx_clr && areq_en);
    assign tok_fire   = (state == ST_TOKEN) && tok_ack;
    assign judge      = (state == ST_WAIT) && rsp_valid;
    assign is_short   = judge && (kind == RSP_DATA) && (budget == '0) && (rsp_bytes < maxp);
    assign tok_req    = (state == ST_TOKEN);
    assign irq        = rxrdy || stalled || err_flag || nak_to;

    uis_retry #(.NAKL_W(NAKL_W), .ERR_TRIES(ERR_TRIES)) retry_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .judge(judge), .kind(kind),
        .nak_lim(nak_lim), .nak_expire(nak_expire), .err_expire(err_expire)
    );

    uis_budget #(.CNT_W(CNT_W)) budget_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && reg_addr == A_BUDG),
        .wr_val(reg_wdata[CNT_W-1:0]), .consume(tok_fire && fresh),
        .cnt(budget), .hit_zero(hit_zero)
    );

    uis_unload #(.MAXP_W(MAXP_W)) unload_i (
        .clk(clk), .rst_n(rst_n), .armed(rxrdy), .rd_stb(fifo_rd),
        .maxp(maxp), .full_read(full_read)
    );

    // Transaction sequencer: idle, token handshake, await response.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else begin
            case (state)
                ST_IDLE:  if (req && !rxrdy && !abort) state <= ST_TOKEN;
                ST_TOKEN: if (tok_ack) state <= ST_WAIT;
                ST_WAIT:  if (rsp_valid) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request flag: set by software or auto-request, cleared by outcomes or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else begin
            if (abort)   req <= 1'b0;
            if (restart) req <= 1'b1;
            if (judge && (kind == RSP_DATA || kind == RSP_STALL || nak_expire || err_expire))
                req <= 1'b0;
        end
    end

    // First-token marker, so the budget counts requests rather than retries.
    always_ff @(posedge clk) begin
        if (!rst_n)        fresh <= 1'b0;
        else if (restart)  fresh <= 1'b1;
        else if (tok_fire) fresh <= 1'b0;
    end

    // Receive-ready flag and the acknowledge pulse tied to its clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxrdy    <= 1'b0;
            ack_send <= 1'b0;
        end else begin
            ack_send <= rx_clr;
            if (rx_clr) rxrdy <= 1'b0;
            if (judge && kind == RSP_DATA) rxrdy <= 1'b1;
        end
    end

    // Sticky outcome flags, cleared only by a software write of zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stalled  <= 1'b0;
            err_flag <= 1'b0;
            nak_to   <= 1'b0;
        end else begin
            if (sw_stat && !reg_wdata[B_STALL]) stalled  <= 1'b0;
            if (sw_stat && !reg_wdata[B_ERROR]) err_flag <= 1'b0;
            if (sw_stat && !reg_wdata[B_NAKTO]) nak_to   <= 1'b0;
            if (judge && kind == RSP_STALL) stalled  <= 1'b1;
            if (err_expire)                 err_flag <= 1'b1;
            if (nak_expire)                 nak_to   <= 1'b1;
        end
    end

    // Mode bits; auto-request is also dropped by the budget or a short packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aclr_en <= 1'b0;
            areq_en <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_MODE) begin
                aclr_en <= reg_wdata[B_ACLR];
                areq_en <= reg_wdata[B_AREQ];
            end
            if (hit_zero || is_short) areq_en <= 1'b0;
        end
    end

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maxp    <= '0;
            nak_lim <= '0;
        end else begin
            if (reg_wr && reg_addr == A_MAXP) maxp    <= reg_wdata[MAXP_W-1:0];
            if (reg_wr && reg_addr == A_NAKL) nak_lim <= reg_wdata[NAKL_W-1:0];
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT: begin
                reg_rdata[B_REQ]   = req;
                reg_rdata[B_RXRDY] = rxrdy;
                reg_rdata[B_STALL] = stalled;
                reg_rdata[B_ERROR] = err_flag;
                reg_rdata[B_NAKTO] = nak_to;
            end
            A_MODE: begin
                reg_rdata[B_ACLR] = aclr_en;
                reg_rdata[B_AREQ] = areq_en;
            end
            A_MAXP:  reg_rdata[MAXP_W-1:0] = maxp;
            A_BUDG:  reg_rdata[CNT_W-1:0]  = budget;
            A_NAKL:  reg_rdata[NAKL_W-1:0] = nak_lim;
            default: reg_rdata = '0;
        endcase
    end

    // R1
    tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_req && !tok_ack) |=> tok_req);
    // R2
    no_tok_rxrdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxrdy |-> !tok_req);
    // R3
    ack_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_send |-> (!rxrdy && $past(rxrdy)));
    // R9
    stall_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (judge && kind == RSP_STALL && !sw_stat) |=> (!req && stalled));
endmodule

// File: tb/usb_in_sched_tb_top.sv
`timescale 1ns/1ps
module usb_in_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tok_req;
    logic        tok_ack = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_kind = '0;
    logic [10:0] rsp_bytes = '0;
    logic        fifo_rd = 1'b0;
    logic        ack_send;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int tok_cnt = 0;
    int ack_cnt = 0;
    bit done = 0;

    typedef struct {
        logic [2:0]  addr;
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    usb_in_sched dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_req(tok_req),
        .tok_ack(tok_ack), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_bytes(rsp_bytes), .fifo_rd(fifo_rd), .ack_send(ack_send), .irq(irq)
    );

    // Counts accepted tokens and acknowledge pulses.
    always @(posedge clk) begin
        if (rst_n) begin
            if (tok_req && tok_ack) tok_cnt++;
            if (ack_send) ack_cnt++;
        end
    end

    // Scoreboard monitor: pops the expected register value and compares.
    always @(sample_ev) begin
        exp_t e;
        e = sbq.pop_front();
        n_chk++;
        if (reg_rdata !== e.val) begin
            n_err++;
            $display("FAIL %s: reg%0d actual=0x%0h expected=0x%0h", e.tag, e.addr, reg_rdata, e.val);
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_reg(logic [2:0] a, logic [15:0] v, string tag);
        exp_t e;
        e.addr = a; e.val = v; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        reg_addr = a;
        #1 -> sample_ev;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Device model: wait for a token, accept it, report one response.
    task automatic serve(logic [1:0] k, logic [10:0] nb);
        while (!tok_req) @(negedge clk);
        tok_ack = 1'b1;
        @(negedge clk);
        tok_ack = 1'b0;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = k; rsp_bytes = nb;
        @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle_chk(string tag, int n);
        int t0 = tok_cnt;
        repeat (n) @(negedge clk);
        chk(tag, tok_cnt, t0);
        chk(tag, int'(tok_req), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int t0, a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset values
        expect_reg(0, 16'h0000, "R13 status");
        expect_reg(1, 16'h0000, "R13 mode");
        expect_reg(3, 16'h0000, "R13 budget");
        chk("R13 tok_req", int'(tok_req), 0);
        chk("R13 irq", int'(irq), 0);

        wr(2, 16'd8); wr(4, 16'd0); wr(3, 16'd0);

        // R1 / R2: software request, full-size data packet
        t0 = tok_cnt;
        wr(0, 16'h001F);
        serve(2'd0, 11'd8);
        chk("R1 token issued", tok_cnt - t0, 1);
        expect_reg(0, 16'h0002, "R2 rxrdy set, req cleared");
        chk("R2 irq", int'(irq), 1);
        idle_chk("R2 no token while rxrdy", 8);

        // R3: software clear of rxrdy acknowledges once; writing 1 has no effect
        wr(0, 16'h001E);
        expect_reg(0, 16'h0002, "R3 write-one keeps rxrdy");
        a0 = ack_cnt;
        wr(0, 16'h001C);
        expect_reg(0, 16'h0000, "R3 rxrdy cleared");
        chk("R3 ack pulse", ack_cnt - a0, 1);
        chk("R3 irq low", int'(irq), 0);
        idle_chk("R3 no auto token", 10);

        // R4 / R6: auto-request with a budget of two
        wr(1, 16'h0002); wr(3, 16'd2);
        t0 = tok_cnt;
        wr(0, 16'h0001);
        serve(2'd0, 11'd8);
        expect_reg(3, 16'h0001, "R6 budget stepped");
        expect_reg(1, 16'h0002, "R6 autoreq kept");
        wr(0, 16'h0000);
        serve(2'd0, 11'd8);
        chk("R4 re-armed token", tok_cnt - t0, 2);
        expect_reg(3, 16'h0000, "R6 budget zero");
        expect_reg(1, 16'h0000, "R6 autoreq cleared");
        wr(0, 16'h0000);
        idle_chk("R6 no token after budget", 10);

        // R5: auto-clear after a max-payload read
        wr(1, 16'h0001);
        wr(0, 16'h0001);
        serve(2'd0, 11'd8);
        a0 = ack_cnt;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk) fifo_rd = 1'b1;
            @(negedge clk) fifo_rd = 1'b0;
        end
        expect_reg(0, 16'h0002, "R5 rxrdy held at 7 bytes");
        @(negedge clk) fifo_rd = 1'b1;
        @(negedge clk) fifo_rd = 1'b0;
        expect_reg(0, 16'h0000, "R5 rxrdy auto-cleared");
        chk("R5 ack pulse", ack_cnt - a0, 1);

        // R7: unknown length ends on a short packet
        wr(1, 16'h0002);
        t0 = tok_cnt;
        wr(0, 16'h0001);
        serve(2'd0, 11'd8);
        wr(0, 16'h0000);
        serve(2'd0, 11'd8);
        wr(0, 16'h0000);
        serve(2'd0, 11'd3);
        expect_reg(1, 16'h0000, "R7 short clears autoreq");
        wr(0, 16'h0000);
        idle_chk("R7 no token after short", 10);
        chk("R7 token count", tok_cnt - t0, 3);

        // R8: NAK limit of three
        wr(4, 16'd3);
        t0 = tok_cnt;
        wr(0, 16'h0001);
        repeat (3) serve(2'd1, 11'd0);
        expect_reg(0, 16'h0010, "R8 NAK timeout");
        idle_chk("R8 no retry after limit", 10);
        chk("R8 token count", tok_cnt - t0, 3);
        // R11 sticky flag and irq
        chk("R11 irq from flag", int'(irq), 1);
        wr(0, 16'h001C);
        expect_reg(0, 16'h0010, "R11 write-one keeps flag");
        wr(0, 16'h0000);
        expect_reg(0, 16'h0000, "R11 write-zero clears flag");

        // R8: limit zero retries forever
        wr(4, 16'd0);
        t0 = tok_cnt;
        wr(0, 16'h0001);
        repeat (5) serve(2'd1, 11'd0);
        serve(2'd0, 11'd4);
        expect_reg(0, 16'h0002, "R8 unlimited NAK then data");
        chk("R8 unlimited token count", tok_cnt - t0, 6);
        wr(0, 16'h0000);

        // R9: STALL is final
        t0 = tok_cnt;
        wr(0, 16'h0001);
        serve(2'd2, 11'd0);
        expect_reg(0, 16'h0004, "R9 stalled");
        idle_chk("R9 no retry", 10);
        chk("R9 token count", tok_cnt - t0, 1);
        wr(0, 16'h0000);

        // R10: three bad responses
        t0 = tok_cnt;
        wr(0, 16'h0001);
        repeat (3) serve(2'd3, 11'd0);
        expect_reg(0, 16'h0008, "R10 error flag");
        idle_chk("R10 no retry after error", 10);
        chk("R10 token count", tok_cnt - t0, 3);
        wr(0, 16'h0000);
        // R10: a NAK resets the run of bad responses
        wr(0, 16'h0001);
        serve(2'd3, 11'd0); serve(2'd3, 11'd0); serve(2'd1, 11'd0);
        serve(2'd3, 11'd0); serve(2'd3, 11'd0); serve(2'd0, 11'd8);
        expect_reg(0, 16'h0002, "R10 run reset by NAK");
        wr(0, 16'h0000);

        // R12: abort while awaiting a response stops the retry
        wr(0, 16'h0001);
        while (!tok_req) @(negedge clk);
        tok_ack = 1'b1;
        @(negedge clk);
        tok_ack = 1'b0;
        wr(0, 16'h0000);
        rsp_valid = 1'b1; rsp_kind = 2'd3;
        @(negedge clk);
        rsp_valid = 1'b0;
        idle_chk("R12 abort stops retry", 12);
        expect_reg(0, 16'h0000, "R12 status after abort");

        finish_run();
    end
endmodule